// File: doc/BRIEF.md
# Glyph Outline Generator

This block decides, one dot per clock, whether a dot of a character cell is shown as background, as foreground or as an outline colour. The cell is 10 dots wide and 16 scan lines tall. For each dot, the caller presents three font rows: the row above the current scan line, the current row and the row below. The caller also gives the line number within the cell, the dot column and the character code. The block looks at the 3 by 3 group of dots around the current dot and classifies it. The result comes out registered, one clock later, together with a valid flag.

The mode input selects the outline style. Plain mode gives only foreground and background. Border mode rings the glyph on all four sides. Shadow mode adds outline dots only to the right of and below lit dots. Two character codes are fixed: code 0x00 is always empty and code 0x7F is always fully lit, whatever the font rows hold. Neighbours that lie outside the cell count as unlit, so the block never reaches into the cells next to it. Glyphs should leave at least one blank dot on every edge of the cell so that their outline fits inside it.

The output stage is a two-state machine. `ST_IDLE` means no dot is being emitted. `ST_EMIT` means the registered dot code is valid. The transitions are:
- `ST_IDLE` to `ST_EMIT` when a dot is accepted.
- `ST_EMIT` stays in `ST_EMIT` on back-to-back dots.
- `ST_EMIT` to `ST_IDLE` when no dot is offered.
- `ST_IDLE` stays in `ST_IDLE` otherwise.

Top module: `glyph_outline_gen`

## Requirements
- R1: While reset is asserted (rst_n low) and after it, until the first accepted dot, valid_o is 0 and pix_o is 0 (background).
- R2: A dot offered with dot_valid_i high at a clock edge appears on pix_o with valid_o high after exactly one clock. When no dot was offered at the previous edge, valid_o is 0 and pix_o is 0.
- R3: mode_i values 0 and 3 are plain mode. In plain mode pix_o is 1 (foreground) when the current dot is lit and 0 otherwise. The current dot is bit dot_i of row_cur_i, where bit 0 is the leftmost column. The value 2 (outline) never appears in plain mode.
- R4: mode_i = 1 is border mode. A lit dot gives 1. An unlit dot gives 2 (outline) if any of its eight neighbours is lit, and 0 otherwise.
- R5: mode_i = 2 is shadow mode. A lit dot gives 1. An unlit dot gives 2 if the dot to its left, the dot above it or the dot above-left of it is lit, and 0 otherwise.
- R6: Neighbours outside the cell count as unlit. This covers row_above_i at line 0, row_below_i at line 15, the column left of column 0 and the column right of column 9.
- R7: Character code 0x00 gives 0 for every dot in every mode, whatever the rows hold.
- R8: Character code 0x7F gives 1 for every dot in every mode, whatever the rows hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_valid_i | input | 1 | A dot is offered this cycle |
| mode_i | input | 2 | 0/3 plain, 1 border, 2 shadow |
| char_code_i | input | 7 | Character code of the cell |
| line_i | input | 4 | Scan line within the cell, 0 = top |
| dot_i | input | 4 | Dot column within the cell, 0 = left |
| row_above_i | input | 10 | Font row of line_i-1, bit n = column n |
| row_cur_i | input | 10 | Font row of line_i |
| row_below_i | input | 10 | Font row of line_i+1 |
| valid_o | output | 1 | pix_o holds a dot result |
| pix_o | output | 2 | 0 background, 1 foreground, 2 outline |

## Verification
Every result is due exactly one clock after the dot is offered. The bench changes inputs on the falling edge and compares pix_o and valid_o on the next falling edge. Each dot is therefore checked at the first moment its registered value is visible, before the next dot replaces it. After each scan line the bench inserts an idle cycle and checks one clock later that valid_o has dropped and pix_o has returned to background. During reset it checks the reset values. The sweep covers every line and column of the cell, in every mode, for several glyphs. At line 0 and line 15 it drives all-ones rows from outside the cell, so any leak across the cell edge shows as a wrong code.

// File: rtl/gog_pkg.sv
package gog_pkg;

    typedef enum logic [1:0] {
        MODE_PLAIN     = 2'd0,
        MODE_BORDER    = 2'd1,
        MODE_SHADOW    = 2'd2,
        MODE_PLAIN_ALT = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        PIX_BG      = 2'd0,
        PIX_FG      = 2'd1,
        PIX_OUTLINE = 2'd2,
        PIX_RSVD    = 2'd3
    } pix_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } out_state_e;

    typedef struct packed {
        logic ul;
        logic u;
        logic ur;
        logic l;
        logic c;
        logic r;
        logic dl;
        logic d;
        logic dr;
    } nbhd_t;

endpackage

// File: rtl/gog_window.sv
module gog_window
    import gog_pkg::*;
#(
    parameter int CELL_W     = 10,
    parameter int CELL_H     = 16,
    parameter int CODE_W     = 7,
    parameter int BLANK_CODE = 0,
    parameter int FULL_CODE  = 127,
    parameter int LINE_W     = $clog2(CELL_H),
    parameter int DOT_W      = $clog2(CELL_W)
) (
    input  logic [CODE_W-1:0] char_code_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [DOT_W-1:0]  dot_i,
    input  logic [CELL_W-1:0] row_above_i,
    input  logic [CELL_W-1:0] row_cur_i,
    input  logic [CELL_W-1:0] row_below_i,
    output nbhd_t             nb_o
);

    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(CELL_H - 1);

    logic              is_blank;
    logic              is_full;
    logic              has_up;
    logic              has_dn;
    logic [CELL_W-1:0] up_row;
    logic [CELL_W-1:0] mid_row;
    logic [CELL_W-1:0] dn_row;
    int                col;

    function automatic logic pick(input logic [CELL_W-1:0] row, input int idx);
        logic [DOT_W-1:0] sel;
        sel = idx[DOT_W-1:0];
        if (idx < 0 || idx >= CELL_W) begin
            return 1'b0;
        end
        return row[sel];
    endfunction

    assign is_blank = (char_code_i == CODE_W'(BLANK_CODE));
    assign is_full  = (char_code_i == CODE_W'(FULL_CODE));
    assign has_up   = (line_i != '0);
    assign has_dn   = (line_i != LAST_LINE);
    assign col      = int'(dot_i);

    // Fixed codes override the font rows before any neighbour is taken.
    always_comb begin
        if (is_blank) begin
            up_row  = '0;
            mid_row = '0;
            dn_row  = '0;
        end else if (is_full) begin
            up_row  = '1;
            mid_row = '1;
            dn_row  = '1;
        end else begin
            up_row  = row_above_i;
            mid_row = row_cur_i;
            dn_row  = row_below_i;
        end
    end

    // Rows outside the cell are masked off.
    always_comb begin
        nb_o.ul = has_up & pick(up_row, col - 1);
        nb_o.u  = has_up & pick(up_row, col);
        nb_o.ur = has_up & pick(up_row, col + 1);
        nb_o.l  = pick(mid_row, col - 1);
        nb_o.c  = pick(mid_row, col);
        nb_o.r  = pick(mid_row, col + 1);
        nb_o.dl = has_dn & pick(dn_row, col - 1);
        nb_o.d  = has_dn & pick(dn_row, col);
        nb_o.dr = has_dn & pick(dn_row, col + 1);
    end

endmodule

// File: rtl/gog_classify.sv
module gog_classify
    import gog_pkg::*;
(
    input  mode_e mode_i,
    input  nbhd_t nb_i,
    output pix_e  pix_o
);

    logic ring_hit;
    logic shadow_hit;

    assign ring_hit   = nb_i.ul | nb_i.u | nb_i.ur | nb_i.l |
                        nb_i.r  | nb_i.dl | nb_i.d | nb_i.dr;
    assign shadow_hit = nb_i.l | nb_i.u | nb_i.ul;

    always_comb begin
        unique case (mode_i)
            MODE_BORDER: begin
                if (nb_i.c)        pix_o = PIX_FG;
                else if (ring_hit) pix_o = PIX_OUTLINE;
                else               pix_o = PIX_BG;
            end
            MODE_SHADOW: begin
                if (nb_i.c)          pix_o = PIX_FG;
                else if (shadow_hit) pix_o = PIX_OUTLINE;
                else                 pix_o = PIX_BG;
            end
            default: begin
                pix_o = nb_i.c ? PIX_FG : PIX_BG;
            end
        endcase
    end

endmodule

// File: rtl/glyph_outline_gen.sv
module glyph_outline_gen
    import gog_pkg::*;
#(
    parameter int CELL_W     = 10,
    parameter int CELL_H     = 16,
    parameter int CODE_W     = 7,
    parameter int BLANK_CODE = 0,
    parameter int FULL_CODE  = 127,
    parameter int LINE_W     = $clog2(CELL_H),
    parameter int DOT_W      = $clog2(CELL_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_valid_i,
    input  logic [1:0]        mode_i,
    input  logic [CODE_W-1:0] char_code_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [DOT_W-1:0]  dot_i,
    input  logic [CELL_W-1:0] row_above_i,
    input  logic [CELL_W-1:0] row_cur_i,
    input  logic [CELL_W-1:0] row_below_i,
    output logic              valid_o,
    output logic [1:0]        pix_o
);

    nbhd_t      nb;
    pix_e       pix_d;
    pix_e       pix_q;
    mode_e      mode;
    out_state_e state_q;
    out_state_e state_d;

    assign mode = mode_e'(mode_i);

    gog_window #(
        .CELL_W     (CELL_W),
        .CELL_H     (CELL_H),
        .CODE_W     (CODE_W),
        .BLANK_CODE (BLANK_CODE),
        .FULL_CODE  (FULL_CODE),
        .LINE_W     (LINE_W),
        .DOT_W      (DOT_W)
    ) window_i (
        .char_code_i (char_code_i),
        .line_i      (line_i),
        .dot_i       (dot_i),
        .row_above_i (row_above_i),
        .row_cur_i   (row_cur_i),
        .row_below_i (row_below_i),
        .nb_o        (nb)
    );

    gog_classify classify_i (
        .mode_i (mode),
        .nb_i   (nb),
        .pix_o  (pix_d)
    );

    // Next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = dot_valid_i ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = dot_valid_i ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)           pix_q <= PIX_BG;
        else if (dot_valid_i) pix_q <= pix_d;
        else                  pix_q <= PIX_BG;
    end

    assign valid_o = (state_q == ST_EMIT);
    assign pix_o   = pix_q;

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        dot_valid_i |=> valid_o);

    a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_valid_i |=> !valid_o);

    a_r2_idle_background: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> pix_o == PIX_BG);

    a_r3_plain_no_outline: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_valid_i && (mode_i == 2'd0 || mode_i == 2'd3)) |=> pix_o != PIX_OUTLINE);

    a_r5_shadow_origin_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_valid_i && mode_i == 2'd2 && line_i == '0 && dot_i == '0) |=> pix_o != PIX_OUTLINE);

    a_r7_blank_code: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_valid_i && char_code_i == CODE_W'(BLANK_CODE)) |=> pix_o == PIX_BG);

    a_r8_full_code: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_valid_i && char_code_i == CODE_W'(FULL_CODE) && int'(dot_i) < CELL_W)
        |=> pix_o == PIX_FG);

endmodule

// File: tb/glyph_outline_gen_tb.sv
`timescale 1ns/1ps
module glyph_outline_gen_tb_top;

    localparam int CW = 10;
    localparam int CH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dot_valid_i = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic [6:0]    char_code_i = 7'h41;
    logic [3:0]    line_i = '0;
    logic [3:0]    dot_i = '0;
    logic [CW-1:0] row_above_i = '0;
    logic [CW-1:0] row_cur_i = '0;
    logic [CW-1:0] row_below_i = '0;
    logic          valid_o;
    logic [1:0]    pix_o;

    int            checks = 0;
    int            errors = 0;
    logic [CW-1:0] glyph [CH];
    logic [31:0]   lfsr = 32'hACE1_1234;

    always #2 clk = ~clk;

    glyph_outline_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dot_valid_i (dot_valid_i),
        .mode_i      (mode_i),
        .char_code_i (char_code_i),
        .line_i      (line_i),
        .dot_i       (dot_i),
        .row_above_i (row_above_i),
        .row_cur_i   (row_cur_i),
        .row_below_i (row_below_i),
        .valid_o     (valid_o),
        .pix_o       (pix_o)
    );

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic logic lit(input int ln, input int cl, input logic [6:0] code);
        if (ln < 0 || ln >= CH || cl < 0 || cl >= CW) return 1'b0;
        if (code == 7'h00) return 1'b0;
        if (code == 7'h7F) return 1'b1;
        return glyph[ln][cl];
    endfunction

    function automatic logic [1:0] exp_pix(input int md, input logic [6:0] code,
                                           input int ln, input int cl);
        int cnt8;
        int cnt3;
        if (lit(ln, cl, code)) return 2'd1;
        cnt8 = 0;
        for (int dy = -1; dy <= 1; dy++)
            for (int dx = -1; dx <= 1; dx++)
                if (!(dx == 0 && dy == 0) && lit(ln + dy, cl + dx, code)) cnt8++;
        cnt3 = int'(lit(ln, cl - 1, code)) + int'(lit(ln - 1, cl, code)) +
               int'(lit(ln - 1, cl - 1, code));
        if (md == 1) return (cnt8 > 0) ? 2'd2 : 2'd0;
        if (md == 2) return (cnt3 > 0) ? 2'd2 : 2'd0;
        return 2'd0;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load_pattern(input int p);
        for (int ln = 0; ln < CH; ln++) begin
            glyph[ln] = '0;
            for (int cl = 0; cl < CW; cl++) begin
                lfsr = next_rand(lfsr);
                unique case (p)
                    0: glyph[ln][cl] = (ln == 7 && cl == 4);
                    1: glyph[ln][cl] = (ln >= 2 && ln <= 13 && cl >= 2 && cl <= 7) &&
                                       (ln == 2 || ln == 13 || cl == 2 || cl == 7);
                    2: glyph[ln][cl] = lfsr[0];
                    3: glyph[ln][cl] = (ln == 0 || ln == CH - 1 || cl == 0 || cl == CW - 1);
                    4: glyph[ln][cl] = (cl == ln % CW);
                    default: glyph[ln][cl] = lfsr[0] & lfsr[5];
                endcase
            end
        end
    endtask

    string req_of_mode [4] = '{"R3", "R4", "R5", "R3"};

    task automatic sweep(input int md, input logic [6:0] code, input string req);
        mode_i      = md[1:0];
        char_code_i = code;
        for (int ln = 0; ln < CH; ln++) begin
            for (int cl = 0; cl < CW; cl++) begin
                dot_valid_i = 1'b1;
                line_i      = ln[3:0];
                dot_i       = cl[3:0];
                // Outside-cell rows driven all ones: must be ignored (R6)
                row_above_i = (ln == 0)      ? '1 : glyph[ln - 1];
                row_cur_i   = glyph[ln];
                row_below_i = (ln == CH - 1) ? '1 : glyph[ln + 1];
                @(negedge clk);
                check("R2", {1'b0, valid_o}, 2'd1, "valid after one clock");
                check((ln == 0 || ln == CH - 1 || cl == 0 || cl == CW - 1) ? "R6" : req,
                      pix_o, exp_pix(md, code, ln, cl),
                      $sformatf("mode=%0d code=%02h line=%0d dot=%0d", md, code, ln, cl));
            end
            dot_valid_i = 1'b0;
            @(negedge clk);
            check("R2", {1'b0, valid_o}, 2'd0, "valid low in gap");
            check("R2", pix_o, 2'd0, "background in gap");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {1'b0, valid_o}, 2'd0, "valid in reset");
        check("R1", pix_o, 2'd0, "pix in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {1'b0, valid_o}, 2'd0, "valid after reset");
        check("R1", pix_o, 2'd0, "pix after reset");

        for (int p = 0; p < 6; p++) begin
            load_pattern(p);
            for (int md = 0; md < 4; md++) sweep(md, 7'h41, req_of_mode[md]);
        end

        load_pattern(2);
        for (int md = 0; md < 4; md++) sweep(md, 7'h00, "R7");
        load_pattern(0);
        for (int md = 0; md < 4; md++) sweep(md, 7'h7F, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule